// File: doc/BRIEF.md
# Class-Aware Pipeline Issue Interlock

This block sits between decode and issue in an in-order pipeline whose instructions fall into five classes: integer ALU, floating-point ALU, double load, double store and conditional branch. Decode offers one instruction at a time. The offer carries the class, the destination register index and up to two source register indices. The interlock records the last few instructions it let through. It holds back a new instruction until every earlier result it reads has had enough time to arrive.

The wait is not a single load-use rule. It comes from a table keyed by the class of the producer and the class of the consumer. Each cycle that passes after the producer issues, whether it carries a bubble or an unrelated instruction, counts against that latency. When several earlier results feed one instruction, the longest remaining wait sets the stall. The remaining wait is shown on an output so the stall can be observed. A flag marks the instruction that fills the slot after a branch. That slot is always executed, so it issues through the normal interlock path.

The instruction side is a valid/ready stream. Upstream raises `in_valid` with a decoded instruction. The instruction issues on a rising clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, upstream must hold `in_valid` and every instruction field unchanged. The block never takes back a ready it has granted for an unchanged offer.

Top module: `pipe_interlock`

## Requirements
- R1: `in_ready` is high exactly when `stall_cycles` is 0. `issue` is `in_valid && in_ready`. With `in_valid` low, `stall_cycles` is 0.
- R2: Class codes are integer=0, FP ALU=1, double load=2, double store=3, branch=4. An FP ALU result read by the FP ALU instruction right behind it gives `stall_cycles`=3 and three stalled cycles.
- R3: An FP ALU result read by the double store right behind it gives 2 stall cycles.
- R4: A double-load result read by the FP ALU instruction right behind it gives 1 stall cycle.
- R5: Double load to double store, integer to integer, and every class pair not named in R2, R3, R4 or R6 give 0 stall cycles. Stores and branches never act as producers.
- R6: An integer result read by the branch right behind it gives 1 stall cycle.
- R7: After g cycles between producer issue and consumer presentation, the stall is max(0, L-g), where L is the pair latency. While the consumer is held, `stall_cycles` drops by one every cycle.
- R8: When both sources hit earlier producers, the stall is the largest of the individual remaining waits.
- R9: A source or destination index of 0 never creates a dependence. Independent instructions issue on consecutive cycles with no bubble.
- R10: `delay_slot` is high while a valid instruction is offered and the most recently issued instruction was a branch.
- R11: After reset, no earlier producer is recorded, `stall_cycles` is 0 and `delay_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction is offered |
| in_ready | output | 1 | Offered instruction may issue this cycle |
| in_cls | input | 3 | Instruction class code (see R2) |
| in_dst | input | REG_W | Destination register index, 0 = none |
| in_src_a | input | REG_W | First source register index, 0 = unused |
| in_src_b | input | REG_W | Second source register index, 0 = unused |
| issue | output | 1 | Instruction leaves for execution this cycle |
| stall_cycles | output | $clog2(4) | Remaining bubble cycles for the offered instruction |
| delay_slot | output | 1 | Offered instruction fills a branch delay slot |

## Verification
The bench builds the block with REG_W=3, so only eight register indices exist and the full space of collisions, misses and index-0 cases is small. For that configuration it sweeps every producer class against every consumer class, at gaps of zero to three cycles, with the dependence on either source or absent. This covers every table entry and every point where the remaining wait reaches zero. Hand-built sequences then cover several producers feeding one instruction, back-to-back independent issue and the reset state.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    K_INT = 3'd0,
    K_FPA = 3'd1,
    K_LDD = 3'd2,
    K_STD = 3'd3,
    K_BR  = 3'd4
  } iclass_e;

  // Longest producer/consumer latency in the table below.
  localparam int unsigned MAX_LAT = 3;

  // Required bubble count between a producer and a dependent consumer.
  function automatic int unsigned pair_lat(iclass_e prod, iclass_e cons);
    int unsigned l;
    l = 0;
    unique case (prod)
      K_FPA: begin
        if (cons == K_FPA) l = 3;
        else if (cons == K_STD) l = 2;
      end
      K_LDD: begin
        if (cons == K_FPA) l = 1;
      end
      K_INT: begin
        if (cons == K_BR) l = 1;
      end
      default: l = 0;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/ilk_history.sv
module ilk_history
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  iclass_e          push_cls,
  input  logic [REG_W-1:0] push_dst,
  output logic             h_vld [DEPTH],
  output iclass_e          h_cls [DEPTH],
  output logic [REG_W-1:0] h_dst [DEPTH]
);

  // Slot k holds the instruction issued k+1 cycles ago (or a bubble).
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          h_vld[k] <= 1'b0;
          h_cls[k] <= K_INT;
          h_dst[k] <= '0;
        end else begin
          h_vld[k] <= push;
          h_cls[k] <= push ? push_cls : K_INT;
          h_dst[k] <= push ? push_dst : '0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          h_vld[k] <= 1'b0;
          h_cls[k] <= K_INT;
          h_dst[k] <= '0;
        end else begin
          h_vld[k] <= h_vld[k-1];
          h_cls[k] <= h_cls[k-1];
          h_dst[k] <= h_dst[k-1];
        end
      end
    end
  end

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned CNT_W = 2
) (
  input  logic             cons_vld,
  input  iclass_e          cons_cls,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             h_vld [DEPTH],
  input  iclass_e          h_cls [DEPTH],
  input  logic [REG_W-1:0] h_dst [DEPTH],
  output logic [CNT_W-1:0] wait_cnt
);

  logic [CNT_W-1:0] rem [DEPTH];

  function automatic logic [CNT_W-1:0] left_over(int unsigned lat, int unsigned age);
    return (lat > age) ? CNT_W'(lat - age) : '0;
  endfunction

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    logic hit_a, hit_b, hit;
    assign hit_a = (src_a != '0) && (src_a == h_dst[k]);
    assign hit_b = (src_b != '0) && (src_b == h_dst[k]);
    assign hit   = h_vld[k] && (h_dst[k] != '0) && (hit_a || hit_b);
    assign rem[k] = hit ? left_over(pair_lat(h_cls[k], cons_cls), k) : '0;
  end

  always_comb begin
    wait_cnt = '0;
    if (cons_vld) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (rem[k] > wait_cnt) wait_cnt = rem[k];
      end
    end
  end

endmodule

// File: rtl/ilk_branch_slot.sv
module ilk_branch_slot
  import ilk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  iclass_e fire_cls,
  input  logic    offer_vld,
  output logic    in_slot
);

  logic last_was_br;

  always_ff @(posedge clk) begin
    if (!rst_n) last_was_br <= 1'b0;
    else if (fire) last_was_br <= (fire_cls == K_BR);
  end

  assign in_slot = offer_vld && last_was_br;

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  localparam int unsigned DEPTH = MAX_LAT,
  localparam int unsigned CNT_W = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  output logic             issue,
  output logic [CNT_W-1:0] stall_cycles,
  output logic             delay_slot
);

  iclass_e          cls_e;
  logic             h_vld [DEPTH];
  iclass_e          h_cls [DEPTH];
  logic [REG_W-1:0] h_dst [DEPTH];

  assign cls_e = iclass_e'(in_cls);

  ilk_history #(.REG_W(REG_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (issue),
    .push_cls (cls_e),
    .push_dst (in_dst),
    .h_vld    (h_vld),
    .h_cls    (h_cls),
    .h_dst    (h_dst)
  );

  ilk_hazard #(.REG_W(REG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_haz (
    .cons_vld (in_valid),
    .cons_cls (cls_e),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .h_vld    (h_vld),
    .h_cls    (h_cls),
    .h_dst    (h_dst),
    .wait_cnt (stall_cycles)
  );

  ilk_branch_slot u_bslot (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (issue),
    .fire_cls  (cls_e),
    .offer_vld (in_valid),
    .in_slot   (delay_slot)
  );

  assign in_ready = (stall_cycles == '0);
  assign issue    = in_valid && in_ready;

endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_cls,
  input logic [REG_W-1:0] in_dst,
  input logic [REG_W-1:0] in_src_a,
  input logic [REG_W-1:0] in_src_b,
  input logic             issue,
  input logic [CNT_W-1:0] stall_cycles,
  input logic             delay_slot
);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (stall_cycles == '0) && in_ready && !issue);

  p_fpa_fpa_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && $past(in_cls) == 3'd1 && $past(in_dst) != '0 &&
     in_valid && in_cls == 3'd1 && in_src_a == $past(in_dst))
    |-> (stall_cycles == CNT_W'(3)));

  p_int_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && $past(in_cls) == 3'd0 && $past(in_dst) != '0 &&
     in_valid && in_cls == 3'd4 && in_src_a == $past(in_dst))
    |-> (stall_cycles == CNT_W'(1)));

  p_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && !$past(in_ready) && in_valid &&
     $stable(in_cls) && $stable(in_src_a) && $stable(in_src_b))
    |-> (stall_cycles == CNT_W'($past(stall_cycles) - 1'b1)));

  p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src_a == '0 && in_src_b == '0) |-> issue);

  p_delay_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue) && $past(in_cls) == 3'd4) |-> (delay_slot == in_valid));

endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_cls       (in_cls),
  .in_dst       (in_dst),
  .in_src_a     (in_src_a),
  .in_src_b     (in_src_b),
  .issue        (issue),
  .stall_cycles (stall_cycles),
  .delay_slot   (delay_slot)
);

// File: tb/tb_pipe_interlock.sv
`timescale 1ns/1ps
module tb_pipe_interlock;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_cls = 3'd0;
  logic [RW-1:0] in_dst = '0;
  logic [RW-1:0] in_src_a = '0;
  logic [RW-1:0] in_src_b = '0;
  logic          issue;
  logic [1:0]    stall_cycles;
  logic          delay_slot;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pipe_interlock #(.REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .issue(issue), .stall_cycles(stall_cycles), .delay_slot(delay_slot)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Pair latencies written from the requirements.
  function automatic int exp_lat(int p, int c);
    if (p == 1 && c == 1) return 3;
    if (p == 1 && c == 3) return 2;
    if (p == 2 && c == 1) return 1;
    if (p == 0 && c == 4) return 1;
    return 0;
  endfunction

  function automatic string pair_req(int p, int c, int g);
    if (g > 0) return "R7";
    if (p == 1 && c == 1) return "R2";
    if (p == 1 && c == 3) return "R3";
    if (p == 2 && c == 1) return "R4";
    if (p == 0 && c == 4) return "R6";
    return "R5";
  endfunction

  task automatic drive(bit v, int c, int d, int a, int b);
    in_valid = v; in_cls = 3'(c); in_dst = RW'(d); in_src_a = RW'(a); in_src_b = RW'(b);
  endtask

  task automatic idle(int n);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    repeat (n) @(posedge clk);
  endtask

  // Issue one instruction that must not stall.
  task automatic send_free(string req, int c, int d, int a, int b);
    @(negedge clk); drive(1, c, d, a, b);
    #1 check(req, "ready for free instruction", int'(in_ready), 1);
    @(posedge clk);
  endtask

  // Present a consumer, check the first stall count and the stall length.
  task automatic consume(string req, int c, int a, int b, int e, int slot);
    int n;
    @(negedge clk); drive(1, c, 5, a, b);
    #1;
    check(req, "initial stall count", int'(stall_cycles), e);
    if (slot >= 0) check("R10", "delay slot flag", int'(delay_slot), slot);
    n = 0;
    while (!in_ready && n < 8) begin
      @(posedge clk); #1; n++;
    end
    check(req, "stalled cycles", n, e);
    @(posedge clk);
    @(negedge clk); drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11: reset state with an offer that would hit an old producer
    @(negedge clk); drive(1, 1, 2, 3, 4);
    #1;
    check("R11", "stall after reset", int'(stall_cycles), 0);
    check("R11", "ready after reset", int'(in_ready), 1);
    check("R11", "delay slot after reset", int'(delay_slot), 0);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    #1 check("R1", "idle stall count", int'(stall_cycles), 0);

    // R2..R7, R10: full sweep over class pairs, gaps, source position, hit/miss
    for (int p = 0; p < 5; p++)
      for (int c = 0; c < 5; c++)
        for (int g = 0; g < 4; g++)
          for (int pos = 0; pos < 2; pos++)
            for (int m = 0; m < 2; m++) begin
              int e, s;
              idle(4);
              send_free("R9", p, 3, 0, 0);
              if (g > 0) idle(g);
              s = exp_lat(p, c) - g;
              e = (m == 1 && s > 0) ? s : 0;
              consume(m == 1 ? pair_req(p, c, g) : "R9", c,
                      pos == 0 ? (m == 1 ? 3 : 4) : 0,
                      pos == 1 ? (m == 1 ? 3 : 4) : 0,
                      e, p == 4 ? 1 : 0);
            end

    // R8: load r1 then FP ALU r2, consumer reads both -> max(0, 3) = 3
    idle(4);
    send_free("R8", 2, 1, 0, 0);
    send_free("R8", 1, 2, 0, 0);
    consume("R8", 1, 1, 2, 3, -1);

    // R8: FP ALU r1, integer r3, FP ALU reads both -> max(2, 0) = 2
    idle(4);
    send_free("R8", 1, 1, 0, 0);
    send_free("R8", 0, 3, 0, 0);
    consume("R8", 1, 3, 1, 2, -1);

    // R8: FP ALU r1, load r2, store reads both -> max(1, 0) = 1
    idle(4);
    send_free("R8", 1, 1, 0, 0);
    send_free("R8", 2, 2, 0, 0);
    consume("R8", 3, 1, 2, 1, -1);

    // R9: destination index 0 never creates a dependence
    idle(4);
    send_free("R9", 1, 0, 0, 0);
    consume("R9", 1, 0, 0, 0, -1);

    // R9: four independent FP ALU ops issue back to back
    idle(4);
    for (int i = 1; i < 5; i++) begin
      @(negedge clk); drive(1, 1, i + 1, 1, 0);
      #1 check("R9", "back-to-back issue", int'(issue), 1);
      @(posedge clk);
    end

    // R10: branch then a later instruction still counts as the slot
    idle(4);
    send_free("R10", 4, 0, 0, 0);
    idle(2);
    consume("R10", 0, 0, 0, 0, 1);
    consume("R10", 0, 0, 0, 0, 0);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule